// File: doc/BRIEF.md
# Per-Flow Segment Selection Engine

This block decides which segment a hardware transport sends next on each of its flows. Every flow's payload is cut into fixed segments ahead of time, so the engine tracks segments by index only. For each flow it keeps three status bits per segment (acknowledged, lost, already retransmitted), a cumulative acknowledgement point, a next-new-segment pointer, the flow's total segment count, a duplicate-acknowledgement counter and a flag recording acknowledgement progress.

Four event streams drive it. A flow start loads a segment count and clears the flow. Cumulative acknowledgements advance the flow or, when repeated, flag a loss. A periodic timeout tick sweeps the flows one at a time and declares the outstanding segments lost when a flow has made no progress. A select request asks for one segment of a flow. The engine answers a select one cycle later with a flow and segment index, and it always serves lost segments before new ones.

Top module: `segsel_engine`

## Requirements
- R1: After reset no flow is active and `seg_valid` is low; a select on a flow that has not been started produces no segment.
- R2: A start on a flow clears its state, marks it active and sets its segment count to `open_total`, clamped to `WIN_SEGS`. With no losses, selects on it return segment indices 0, 1, 2, ... in order, with `seg_retx`=0. Each answer appears on the clock edge after the select, with `seg_flow` equal to the requested flow.
- R3: A new segment is issued only while the next-new index is below both the flow's segment count and `WIN_SEGS`; otherwise a select with nothing lost yields `seg_valid`=0.
- R4: An acknowledgement carrying index n, with n above the flow's acknowledgement point and not above its next-new index, marks every segment below n acknowledged and moves the acknowledgement point to n. Acknowledged segments are never retransmitted. Acknowledgements with n below the point or above the next-new index are ignored.
- R5: An acknowledgement with n equal to the acknowledgement point, while segments are outstanding, counts as a duplicate. The third consecutive duplicate marks segment n lost, clears its retransmitted bit and restarts the count.
- R6: A select serves the lowest-index segment that is lost, not yet retransmitted and not acknowledged, with `seg_retx`=1, and sets its retransmitted bit. Only when no such segment exists does it issue a new segment.
- R7: Each `tmo_tick` examines one flow: flow 0 on the first tick after reset, then flows 1, 2, and so on, wrapping after the last. An examined active flow that has seen no accepted acknowledgement since its previous examination, and has outstanding segments, gets all of them marked lost with their retransmitted bits cleared. Examination always clears the progress flag.
- R8: If a tick's examined flow also receives an acknowledgement in the same cycle, the acknowledgement is applied and that flow's timeout examination is skipped; the sweep pointer still advances.
- R9: Within one cycle the events on a flow take effect in this order: acknowledgement, then timeout, then selection. A select therefore sees a loss created by an acknowledgement or a timeout in the same cycle.
- R10: A start on a flow overrides every other event on that flow in the same cycle; a select on it in that cycle produces no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_valid | input | 1 | Start a flow |
| open_flow | input | log2(NUM_FLOWS) | Flow being started |
| open_total | input | log2(WIN_SEGS+1) | Number of segments in the flow |
| ack_valid | input | 1 | Cumulative acknowledgement present |
| ack_flow | input | log2(NUM_FLOWS) | Flow acknowledged |
| ack_idx | input | log2(WIN_SEGS+1) | Every segment below this index is acknowledged |
| tmo_tick | input | 1 | Periodic timeout tick, examines one flow |
| sel_valid | input | 1 | Request a segment |
| sel_flow | input | log2(NUM_FLOWS) | Flow for the request |
| seg_valid | output | 1 | A segment was chosen for the previous request |
| seg_flow | output | log2(NUM_FLOWS) | Flow of the chosen segment |
| seg_id | output | log2(WIN_SEGS) | Index of the chosen segment |
| seg_retx | output | 1 | The chosen segment is a retransmission |

## Verification
The hardest state to reach is a timeout loss, because it needs a flow with outstanding segments and no accepted acknowledgement across two visits of the sweep pointer, which moves only on ticks and visits each flow once every eight. The directed part counts ticks exactly. It places an acknowledgement on the very tick that examines the flow, so the skipped examination shows up one full sweep later as a missing loss. The random phase keeps acknowledgement indices within a few steps of each flow's acknowledgement point, which produces runs of duplicates and stale indices. A reference model in the bench tracks every flow and predicts each answer.

// File: rtl/segsel_pkg.sv
package segsel_pkg;

   // Kind of segment a flow slice hands back for a select request.
   typedef enum logic [1:0] {
      PK_NONE = 2'd0,
      PK_NEW  = 2'd1,
      PK_RTX  = 2'd2
   } pick_kind_e;

   localparam int unsigned DUP_LIMIT = 3;

endpackage

// File: rtl/segsel_lowest.sv
module segsel_lowest #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] req,
   output logic             found,
   output logic [IW-1:0]    idx
);

   // Lowest set bit wins: scan downward so the last hit is the lowest.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int j = WIDTH - 1; j >= 0; j--) begin
         if (req[j]) begin
            found = 1'b1;
            idx   = IW'(j);
         end
      end
   end

endmodule

// File: rtl/segsel_flow_upd.sv
module segsel_flow_upd
   import segsel_pkg::*;
#(
   parameter int unsigned WIN_SEGS = 32,
   localparam int unsigned IW = $clog2(WIN_SEGS),
   localparam int unsigned CW = $clog2(WIN_SEGS + 1)
) (
   input  logic [WIN_SEGS-1:0] cur_acked,
   input  logic [WIN_SEGS-1:0] cur_lost,
   input  logic [WIN_SEGS-1:0] cur_rtxed,
   input  logic [CW-1:0]       cur_una,
   input  logic [CW-1:0]       cur_nxt,
   input  logic [CW-1:0]       cur_tot,
   input  logic [1:0]          cur_dup,
   input  logic                cur_prog,
   input  logic                cur_act,
   input  logic                ack_hit,
   input  logic [CW-1:0]       ack_idx,
   input  logic                tmo_hit,
   input  logic                sel_hit,
   input  logic                open_hit,
   input  logic [CW-1:0]       open_total,
   output logic [WIN_SEGS-1:0] new_acked,
   output logic [WIN_SEGS-1:0] new_lost,
   output logic [WIN_SEGS-1:0] new_rtxed,
   output logic [CW-1:0]       new_una,
   output logic [CW-1:0]       new_nxt,
   output logic [CW-1:0]       new_tot,
   output logic [1:0]          new_dup,
   output logic                new_prog,
   output logic                new_act,
   output pick_kind_e          pick_kind,
   output logic [IW-1:0]       pick_id
);

   localparam logic [CW-1:0] WIN_C = CW'(WIN_SEGS);
   localparam logic [1:0]    DUP_LAST = 2'(DUP_LIMIT - 1);

   logic [WIN_SEGS-1:0] mid_acked, mid_lost, mid_rtxed, cand;
   logic [CW-1:0]       mid_una;
   logic [1:0]          mid_dup;
   logic                mid_prog;
   logic                cand_found;
   logic [IW-1:0]       cand_idx;

   // Stage 1: acknowledgement, then timeout (R9 ordering).
   always_comb begin
      mid_acked = cur_acked;
      mid_lost  = cur_lost;
      mid_rtxed = cur_rtxed;
      mid_una   = cur_una;
      mid_dup   = cur_dup;
      mid_prog  = cur_prog;
      if (ack_hit && cur_act) begin
         if (ack_idx > cur_una && ack_idx <= cur_nxt) begin
            for (int j = 0; j < WIN_SEGS; j++) begin
               if (CW'(j) < ack_idx) begin
                  mid_acked[j] = 1'b1;
                  mid_lost[j]  = 1'b0;
               end
            end
            mid_una  = ack_idx;
            mid_dup  = '0;
            mid_prog = 1'b1;
         end else if (ack_idx == cur_una && cur_una < cur_nxt) begin
            if (cur_dup == DUP_LAST) begin
               mid_lost[cur_una[IW-1:0]]  = 1'b1;
               mid_rtxed[cur_una[IW-1:0]] = 1'b0;
               mid_dup = '0;
            end else begin
               mid_dup = cur_dup + 2'd1;
            end
         end
      end
      if (tmo_hit && cur_act) begin
         if (!mid_prog && mid_una < cur_nxt) begin
            for (int j = 0; j < WIN_SEGS; j++) begin
               if (CW'(j) >= mid_una && CW'(j) < cur_nxt) begin
                  mid_lost[j]  = 1'b1;
                  mid_rtxed[j] = 1'b0;
               end
            end
         end
         mid_prog = 1'b0;
      end
   end

   assign cand = mid_lost & ~mid_rtxed & ~mid_acked;

   segsel_lowest #(.WIDTH(WIN_SEGS)) u_lowest (
      .req   (cand),
      .found (cand_found),
      .idx   (cand_idx)
   );

   // Stage 2: selection, then a start overrides everything.
   always_comb begin
      new_acked = mid_acked;
      new_lost  = mid_lost;
      new_rtxed = mid_rtxed;
      new_una   = mid_una;
      new_nxt   = cur_nxt;
      new_tot   = cur_tot;
      new_dup   = mid_dup;
      new_prog  = mid_prog;
      new_act   = cur_act;
      pick_kind = PK_NONE;
      pick_id   = '0;
      if (sel_hit && cur_act) begin
         if (cand_found) begin
            pick_kind           = PK_RTX;
            pick_id             = cand_idx;
            new_rtxed[cand_idx] = 1'b1;
         end else if (cur_nxt < cur_tot && cur_nxt < WIN_C) begin
            pick_kind = PK_NEW;
            pick_id   = cur_nxt[IW-1:0];
            new_nxt   = cur_nxt + CW'(1);
         end
      end
      if (open_hit) begin
         new_acked = '0;
         new_lost  = '0;
         new_rtxed = '0;
         new_una   = '0;
         new_nxt   = '0;
         new_tot   = (open_total > WIN_C) ? WIN_C : open_total;
         new_dup   = '0;
         new_prog  = 1'b0;
         new_act   = 1'b1;
         pick_kind = PK_NONE;
         pick_id   = '0;
      end
   end

endmodule

// File: rtl/segsel_engine.sv
module segsel_engine
   import segsel_pkg::*;
#(
   parameter int unsigned NUM_FLOWS = 8,
   parameter int unsigned WIN_SEGS  = 32,
   localparam int unsigned FW = $clog2(NUM_FLOWS),
   localparam int unsigned IW = $clog2(WIN_SEGS),
   localparam int unsigned CW = $clog2(WIN_SEGS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          open_valid,
   input  logic [FW-1:0] open_flow,
   input  logic [CW-1:0] open_total,
   input  logic          ack_valid,
   input  logic [FW-1:0] ack_flow,
   input  logic [CW-1:0] ack_idx,
   input  logic          tmo_tick,
   input  logic          sel_valid,
   input  logic [FW-1:0] sel_flow,
   output logic          seg_valid,
   output logic [FW-1:0] seg_flow,
   output logic [IW-1:0] seg_id,
   output logic          seg_retx
);

   if (NUM_FLOWS < 2 || (1 << FW) != NUM_FLOWS) begin : g_bad_flows
      $error("NUM_FLOWS must be a power of two, at least 2");
   end
   if (WIN_SEGS < 2 || (1 << IW) != WIN_SEGS) begin : g_bad_win
      $error("WIN_SEGS must be a power of two, at least 2");
   end

   logic [WIN_SEGS-1:0] acked_q [NUM_FLOWS];
   logic [WIN_SEGS-1:0] lost_q  [NUM_FLOWS];
   logic [WIN_SEGS-1:0] rtxed_q [NUM_FLOWS];
   logic [CW-1:0]       una_q   [NUM_FLOWS];
   logic [CW-1:0]       nxt_q   [NUM_FLOWS];
   logic [CW-1:0]       tot_q   [NUM_FLOWS];
   logic [1:0]          dup_q   [NUM_FLOWS];
   logic                prog_q  [NUM_FLOWS];
   logic                act_q   [NUM_FLOWS];

   pick_kind_e          kind_w  [NUM_FLOWS];
   logic [IW-1:0]       id_w    [NUM_FLOWS];
   logic [FW-1:0]       tmo_ptr_q;

   for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_flow
      logic                ack_hit, tmo_hit, sel_hit, open_hit;
      logic [WIN_SEGS-1:0] n_acked, n_lost, n_rtxed;
      logic [CW-1:0]       n_una, n_nxt, n_tot;
      logic [1:0]          n_dup;
      logic                n_prog, n_act;

      assign ack_hit  = ack_valid  && (ack_flow  == FW'(i));
      assign tmo_hit  = tmo_tick   && (tmo_ptr_q == FW'(i)) && !ack_hit;
      assign sel_hit  = sel_valid  && (sel_flow  == FW'(i));
      assign open_hit = open_valid && (open_flow == FW'(i));

      segsel_flow_upd #(.WIN_SEGS(WIN_SEGS)) u_upd (
         .cur_acked  (acked_q[i]),
         .cur_lost   (lost_q[i]),
         .cur_rtxed  (rtxed_q[i]),
         .cur_una    (una_q[i]),
         .cur_nxt    (nxt_q[i]),
         .cur_tot    (tot_q[i]),
         .cur_dup    (dup_q[i]),
         .cur_prog   (prog_q[i]),
         .cur_act    (act_q[i]),
         .ack_hit    (ack_hit),
         .ack_idx    (ack_idx),
         .tmo_hit    (tmo_hit),
         .sel_hit    (sel_hit),
         .open_hit   (open_hit),
         .open_total (open_total),
         .new_acked  (n_acked),
         .new_lost   (n_lost),
         .new_rtxed  (n_rtxed),
         .new_una    (n_una),
         .new_nxt    (n_nxt),
         .new_tot    (n_tot),
         .new_dup    (n_dup),
         .new_prog   (n_prog),
         .new_act    (n_act),
         .pick_kind  (kind_w[i]),
         .pick_id    (id_w[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acked_q[i] <= '0;
            lost_q[i]  <= '0;
            rtxed_q[i] <= '0;
            una_q[i]   <= '0;
            nxt_q[i]   <= '0;
            tot_q[i]   <= '0;
            dup_q[i]   <= '0;
            prog_q[i]  <= 1'b0;
            act_q[i]   <= 1'b0;
         end else begin
            acked_q[i] <= n_acked;
            lost_q[i]  <= n_lost;
            rtxed_q[i] <= n_rtxed;
            una_q[i]   <= n_una;
            nxt_q[i]   <= n_nxt;
            tot_q[i]   <= n_tot;
            dup_q[i]   <= n_dup;
            prog_q[i]  <= n_prog;
            act_q[i]   <= n_act;
         end
      end
   end

   // Sweep pointer for timeout examination; wraps since NUM_FLOWS is 2**FW.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_ptr_q <= '0;
      end else if (tmo_tick) begin
         tmo_ptr_q <= tmo_ptr_q + FW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_valid <= 1'b0;
         seg_flow  <= '0;
         seg_id    <= '0;
         seg_retx  <= 1'b0;
      end else begin
         seg_valid <= sel_valid && (kind_w[sel_flow] != PK_NONE);
         if (sel_valid && kind_w[sel_flow] != PK_NONE) begin
            seg_flow <= sel_flow;
            seg_id   <= id_w[sel_flow];
            seg_retx <= (kind_w[sel_flow] == PK_RTX);
         end
      end
   end

endmodule

// File: rtl/segsel_engine_chk.sv
module segsel_engine_chk #(
   parameter int unsigned NUM_FLOWS = 8,
   parameter int unsigned WIN_SEGS  = 32,
   localparam int unsigned FW = $clog2(NUM_FLOWS),
   localparam int unsigned IW = $clog2(WIN_SEGS),
   localparam int unsigned CW = $clog2(WIN_SEGS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel_valid,
   input logic [FW-1:0]       sel_flow,
   input logic                seg_valid,
   input logic [FW-1:0]       seg_flow,
   input logic [IW-1:0]       seg_id,
   input logic                seg_retx,
   input logic [WIN_SEGS-1:0] acked_q [NUM_FLOWS],
   input logic [WIN_SEGS-1:0] rtxed_q [NUM_FLOWS],
   input logic [CW-1:0]       una_q   [NUM_FLOWS],
   input logic [CW-1:0]       nxt_q   [NUM_FLOWS],
   input logic [CW-1:0]       tot_q   [NUM_FLOWS]
);

   AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> $past(sel_valid));                                   // R2

   AST_RESP_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> seg_flow == $past(sel_flow));                        // R2

   AST_NEW_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_retx) |->
         (nxt_q[seg_flow] == CW'({1'b0, seg_id}) + CW'(1)
          && CW'({1'b0, seg_id}) < tot_q[seg_flow]));                    // R3

   AST_RETX_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_retx) |->
         (rtxed_q[seg_flow][seg_id] && !acked_q[seg_flow][seg_id]));     // R6

   for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_ord
      AST_POINTER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
         (una_q[i] <= nxt_q[i]) && (nxt_q[i] <= tot_q[i])
         && (tot_q[i] <= CW'(WIN_SEGS)));                                // R4
   end

endmodule

bind segsel_engine segsel_engine_chk #(
   .NUM_FLOWS (NUM_FLOWS),
   .WIN_SEGS  (WIN_SEGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_valid (sel_valid),
   .sel_flow  (sel_flow),
   .seg_valid (seg_valid),
   .seg_flow  (seg_flow),
   .seg_id    (seg_id),
   .seg_retx  (seg_retx),
   .acked_q   (acked_q),
   .rtxed_q   (rtxed_q),
   .una_q     (una_q),
   .nxt_q     (nxt_q),
   .tot_q     (tot_q)
);

// File: tb/segsel_engine_tb_top.sv
`timescale 1ns/1ps
module segsel_engine_tb_top;

   localparam int NF = 8;
   localparam int W  = 32;
   localparam int FW = $clog2(NF);
   localparam int IW = $clog2(W);
   localparam int CW = $clog2(W + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          open_valid = 1'b0;
   logic [FW-1:0] open_flow = '0;
   logic [CW-1:0] open_total = '0;
   logic          ack_valid = 1'b0;
   logic [FW-1:0] ack_flow = '0;
   logic [CW-1:0] ack_idx = '0;
   logic          tmo_tick = 1'b0;
   logic          sel_valid = 1'b0;
   logic [FW-1:0] sel_flow = '0;
   logic          seg_valid;
   logic [FW-1:0] seg_flow;
   logic [IW-1:0] seg_id;
   logic          seg_retx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   segsel_engine #(.NUM_FLOWS(NF), .WIN_SEGS(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .open_valid(open_valid), .open_flow(open_flow), .open_total(open_total),
      .ack_valid(ack_valid), .ack_flow(ack_flow), .ack_idx(ack_idx),
      .tmo_tick(tmo_tick),
      .sel_valid(sel_valid), .sel_flow(sel_flow),
      .seg_valid(seg_valid), .seg_flow(seg_flow), .seg_id(seg_id), .seg_retx(seg_retx)
   );

   // Reference model of every flow.
   bit [W-1:0] m_ack [NF];
   bit [W-1:0] m_lost[NF];
   bit [W-1:0] m_rtx [NF];
   int m_una[NF], m_nxt[NF], m_tot[NF], m_dup[NF];
   bit m_prog[NF], m_act[NF];
   int m_ptr = 0;

   task automatic check(string tag, bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_step(input bit ov, input int of, input int ot,
                             input bit av, input int af, input int ai,
                             input bit tk, input bit sv, input int sf,
                             output bit ev, output int eid, output bit ertx);
      ev = 0; eid = 0; ertx = 0;
      if (av && m_act[af] && !(ov && of == af)) begin
         if (ai > m_una[af] && ai <= m_nxt[af]) begin
            for (int j = 0; j < ai; j++) begin
               m_ack[af][j] = 1'b1;
               m_lost[af][j] = 1'b0;
            end
            m_una[af] = ai; m_dup[af] = 0; m_prog[af] = 1'b1;
         end else if (ai == m_una[af] && m_una[af] < m_nxt[af]) begin
            m_dup[af]++;
            if (m_dup[af] == 3) begin
               m_lost[af][m_una[af]] = 1'b1;
               m_rtx[af][m_una[af]] = 1'b0;
               m_dup[af] = 0;
            end
         end
      end
      if (tk) begin
         int f;
         f = m_ptr;
         m_ptr = (m_ptr + 1) % NF;
         if (!(av && af == f) && m_act[f] && !(ov && of == f)) begin
            if (!m_prog[f]) begin
               for (int j = m_una[f]; j < m_nxt[f]; j++) begin
                  m_lost[f][j] = 1'b1;
                  m_rtx[f][j] = 1'b0;
               end
            end
            m_prog[f] = 1'b0;
         end
      end
      if (sv && m_act[sf] && !(ov && of == sf)) begin
         int p;
         p = -1;
         for (int j = W - 1; j >= 0; j--)
            if (m_lost[sf][j] && !m_rtx[sf][j] && !m_ack[sf][j]) p = j;
         if (p >= 0) begin
            ev = 1; eid = p; ertx = 1; m_rtx[sf][p] = 1'b1;
         end else if (m_nxt[sf] < m_tot[sf]) begin
            ev = 1; eid = m_nxt[sf]; m_nxt[sf]++;
         end
      end
      if (ov) begin
         m_ack[of] = '0; m_lost[of] = '0; m_rtx[of] = '0;
         m_una[of] = 0; m_nxt[of] = 0; m_dup[of] = 0; m_prog[of] = 0;
         m_act[of] = 1'b1;
         m_tot[of] = (ot > W) ? W : ot;
      end
   endtask

   // One cycle: drive, advance the model, sample after the edge, compare.
   task automatic step(bit ov, int of, int ot, bit av, int af, int ai,
                       bit tk, bit sv, int sf, string tag);
      bit ev, ertx;
      int eid;
      string t;
      open_valid = ov; open_flow = FW'(of); open_total = CW'(ot);
      ack_valid = av; ack_flow = FW'(af); ack_idx = CW'(ai);
      tmo_tick = tk; sel_valid = sv; sel_flow = FW'(sf);
      model_step(ov, of, ot, av, af, ai, tk, sv, sf, ev, eid, ertx);
      @(posedge clk);
      @(negedge clk);
      t = (tag != "") ? tag : (ev ? (ertx ? "R6" : "R2") : "R3");
      check(t, seg_valid == ev, "seg_valid", int'(seg_valid), int'(ev));
      if (ev && seg_valid) begin
         check(t, int'(seg_flow) == sf, "seg_flow", int'(seg_flow), sf);
         check(t, int'(seg_id) == eid, "seg_id", int'(seg_id), eid);
         check(t, seg_retx == ertx, "seg_retx", int'(seg_retx), int'(ertx));
      end
   endtask

   task automatic sel(int f, string tag);
      step(0, 0, 0, 0, 0, 0, 0, 1, f, tag);
   endtask
   task automatic ack(int f, int n, string tag);
      step(0, 0, 0, 1, f, n, 0, 0, 0, tag);
   endtask
   task automatic tick(string tag);
      step(0, 0, 0, 0, 0, 0, 1, 0, 0, tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog expired actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd51731));
      for (int i = 0; i < NF; i++) begin
         m_ack[i] = '0; m_lost[i] = '0; m_rtx[i] = '0;
         m_una[i] = 0; m_nxt[i] = 0; m_tot[i] = 0; m_dup[i] = 0;
         m_prog[i] = 0; m_act[i] = 0;
      end
      repeat (3) @(negedge clk);
      check("R1", seg_valid == 1'b0, "seg_valid in reset", int'(seg_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", seg_valid == 1'b0, "seg_valid after reset", int'(seg_valid), 0);
      sel(3, "R1");                          // R1: flow never started
      step(1, 0, 5, 0, 0, 0, 0, 1, 0, "R10"); // R10: start with select on same flow
      for (int k = 0; k < 5; k++) sel(0, "R2");
      sel(0, "R3");                          // R3: count exhausted
      step(1, 1, 40, 0, 0, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 32; k++) sel(1, "R2");
      sel(1, "R2");                          // R2: clamped to window of 32
      ack(0, 7, "R4");                       // R4: beyond next-new, ignored
      ack(0, 2, "R4");
      ack(0, 1, "R4");                       // R4: stale, ignored, no duplicate
      ack(0, 2, "R5");
      ack(0, 2, "R5");
      step(0, 0, 0, 1, 0, 2, 0, 1, 0, "R9"); // R5/R9: third duplicate, same-cycle select
      sel(0, "R6");                          // R6: already retransmitted
      // R8: tick examines flow 0 while it is acknowledged; examination skipped.
      step(0, 0, 0, 1, 0, 3, 1, 0, 0, "R8");
      for (int k = 0; k < 7; k++) tick("R7");
      tick("R8");                            // flow 0 again: progress seen, clear only
      sel(0, "R8");
      for (int k = 0; k < 7; k++) tick("R7");
      tick("R7");                            // flow 0, no progress: 3 and 4 lost
      sel(0, "R4");                          // R4: acked 0..2 not resent, expect 3
      sel(0, "R7");
      sel(0, "R7");
      // Random phase.
      for (int f = 0; f < NF; f++) step(1, f, int'($urandom_range(1, 40)), 0, 0, 0, 0, 0, 0, "R2");
      for (int k = 0; k < 4000; k++) begin
         bit ov, av, tk, sv;
         int of, ot, af, ai, sf;
         ov = ($urandom_range(0, 99) == 0);
         of = int'($urandom_range(0, NF - 1));
         ot = int'($urandom_range(0, 40));
         av = ($urandom_range(0, 2) == 0);
         af = int'($urandom_range(0, NF - 1));
         ai = m_una[af] + int'($urandom_range(0, 4)) - 1;
         if (ai < 0) ai = 0;
         if (ai > W) ai = W;
         tk = ($urandom_range(0, 3) == 0);
         sv = ($urandom_range(0, 1) == 0);
         sf = int'($urandom_range(0, NF - 1));
         step(ov, of, ot, av, af, ai, tk, sv, sf, "");
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule